// File: doc/BRIEF.md
# Data-Poll Completion Checker

This block runs on the host side of a parallel NOR flash interface. It decides whether an embedded program or erase operation has finished, using the status bit that reports the complement of the written datum until the operation completes. A single-cycle `start` loads the status address and the byte the host expects to find. For an erase, that byte is 0xFF. The block then keeps issuing reads at that address through a request/acknowledge read port. It classifies each returned byte from two positions: bit 7 is the polled datum bit and bit 5 is the device's time-limit flag.

If bit 7 equals bit 7 of the expected byte, the operation has finished. Bit 7 can settle before the rest of the byte, so the block issues one more read and hands that byte to the host as the result. If bit 7 still differs, the block checks bit 5. With bit 5 low it keeps polling. With bit 5 high it makes exactly one confirming read, because bit 7 may have flipped in the same cycle as bit 5. Only if that confirming read still disagrees does the block report failure. An optional cycle watchdog on the host side bounds the polling phase.

Top module: `dpoll_checker`

## Requirements
- R1: Every read goes out on `rd_addr` with the address captured at `start`, and `rd_addr` stays unchanged while `rd_req` is held.
- R2: A read whose bit 7 equals bit 7 of the captured expected byte ends polling. The block then issues one further read and finishes with pass.
- R3: A read whose bit 7 differs and whose bit 5 is 0 causes another read at the same address. This repeats for as long as such bytes arrive.
- R4: A read whose bit 7 differs and whose bit 5 is 1 causes exactly one confirming read. If that read's bit 7 matches, the block follows R2. Otherwise it finishes with fail, whatever bit 5 of the confirming read holds.
- R5: On pass, `data_out` carries the byte of the read that followed the matching read, and `data_out_valid` is high for one cycle together with `done`. On fail, `data_out_valid` stays low.
- R6: `done` is high for exactly one cycle per operation. In that cycle exactly one of `pass` and `fail` is high. Both are low in every other cycle, and `rd_req` is low while `done` is high.
- R7: A `start` seen while an operation is in progress has no effect on the address, the expected byte or the outcome.
- R8: While the synchronous reset `rst` is high, and after it is released, the block is idle. `rd_req`, `done`, `pass`, `fail` and `data_out_valid` are 0 until the next `start`.
- R9: If the watchdog is enabled and no verdict is reached within `WDOG_LIMIT` cycles of polling, the block finishes with fail. `done` rises `WDOG_LIMIT + 1` clock edges after the edge that took `start`. The closing data read after a match is not timed.
- R10: A read completes in a cycle where `rd_req` and `rd_ack` are both high, with `rd_data` valid in that cycle. Without `rd_ack`, `rd_req` stays high until the read completes or the watchdog ends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin polling |
| valid_addr | input | ADDR_W | Address at which status is read |
| expected_data | input | DATA_W | Byte expected when the operation completes (0xFF for erase) |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` valid in this cycle |
| rd_data | input | DATA_W | Byte returned by the read |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed, valid with `done` |
| fail | output | 1 | Operation timed out or watchdog expired, valid with `done` |
| data_out | output | DATA_W | Trusted byte read after a match |
| data_out_valid | output | 1 | `data_out` strobe, high with `done` on pass |

## Verification
The properties assume that `rd_ack` is acknowledged only while `rd_req` is high and that `rd_data` is meaningful only in the acknowledging cycle. They also assume that `start` is a single-cycle pulse and that reset is held from time zero. The bench's read responder drives `rd_ack` and `rd_data` half a cycle away from the sampling edge, and only while it sees `rd_req`. It can also withhold the acknowledge on alternate cycles, so stalled reads stay within the handshake the assertions expect. Starts are pulsed for one cycle, including the one deliberately issued mid-operation.

// File: rtl/dpoll_pkg.sv
package dpoll_pkg;

    // Bit positions inside a status byte that the checker decodes.
    localparam int POLL_BIT = 7;
    localparam int TOUT_BIT = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_POLL    = 2'd1,
        ST_RECHECK = 2'd2,
        ST_FINAL   = 2'd3
    } dp_state_e;

    typedef enum logic [1:0] {
        VD_MATCH   = 2'd0,
        VD_RETRY   = 2'd1,
        VD_SUSPECT = 2'd2
    } dp_verdict_e;

    function automatic dp_verdict_e classify(input logic dq_poll,
                                             input logic want_poll,
                                             input logic dq_tout);
        if (dq_poll == want_poll) return VD_MATCH;
        if (dq_tout)              return VD_SUSPECT;
        return VD_RETRY;
    endfunction

endpackage

// File: rtl/dpoll_compare.sv
module dpoll_compare
    import dpoll_pkg::*;
(
    input  logic        dq_poll,
    input  logic        dq_tout,
    input  logic        want_poll,
    output dp_verdict_e verdict
);

    always_comb begin
        verdict = classify(dq_poll, want_poll, dq_tout);
    end

endmodule

// File: rtl/dpoll_watchdog.sv
module dpoll_watchdog #(
    parameter int LIMIT = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    assign expired = (cnt_q == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dpoll_fsm.sv
module dpoll_fsm
    import dpoll_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] valid_addr,
    input  logic              want_poll_in,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    input  dp_verdict_e       verdict,
    input  logic              wd_expired,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              want_poll,
    output logic              poll_active,
    output logic              is_idle,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [DATA_W-1:0] data_out,
    output logic              data_out_valid
);

    dp_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              want_q;
    logic              done_q, pass_q, fail_q, dov_q;
    logic [DATA_W-1:0] dout_q;
    logic              xfer;

    assign xfer        = rd_req && rd_ack;
    assign rd_req      = (state_q != ST_IDLE);
    assign rd_addr     = addr_q;
    assign want_poll   = want_q;
    assign poll_active = (state_q == ST_POLL) || (state_q == ST_RECHECK);
    assign is_idle     = (state_q == ST_IDLE);

    assign done           = done_q;
    assign pass           = pass_q;
    assign fail           = fail_q;
    assign data_out       = dout_q;
    assign data_out_valid = dov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            want_q  <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            dov_q   <= 1'b0;
            dout_q  <= '0;
        end else begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            dov_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q  <= valid_addr;
                        want_q  <= want_poll_in;
                        state_q <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (wd_expired) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (xfer) begin
                        unique case (verdict)
                            VD_MATCH:   state_q <= ST_FINAL;
                            VD_SUSPECT: state_q <= ST_RECHECK;
                            default:    state_q <= ST_POLL;
                        endcase
                    end
                end
                ST_RECHECK: begin
                    if (wd_expired) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (xfer) begin
                        if (verdict == VD_MATCH) begin
                            state_q <= ST_FINAL;
                        end else begin
                            done_q  <= 1'b1;
                            fail_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_FINAL: begin
                    if (xfer) begin
                        dout_q  <= rd_data;
                        dov_q   <= 1'b1;
                        done_q  <= 1'b1;
                        pass_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dpoll_checker.sv
module dpoll_checker
    import dpoll_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 8,
    parameter bit WDOG_EN    = 1'b1,
    parameter int WDOG_LIMIT = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] valid_addr,
    input  logic [DATA_W-1:0] expected_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [DATA_W-1:0] data_out,
    output logic              data_out_valid
);

    dp_verdict_e verdict;
    logic        want_poll;
    logic        poll_active;
    logic        is_idle;
    logic        wd_expired;
    logic        exp_unused;

    // Only the polled bit of the expected byte steers the decision.
    assign exp_unused = ^expected_data;

    dpoll_compare i_compare (
        .dq_poll   (rd_data[POLL_BIT]),
        .dq_tout   (rd_data[TOUT_BIT]),
        .want_poll (want_poll),
        .verdict   (verdict)
    );

    generate
        if (WDOG_EN) begin : g_wdog
            dpoll_watchdog #(.LIMIT(WDOG_LIMIT)) i_watchdog (
                .clk     (clk),
                .rst     (rst),
                .clear   (is_idle),
                .run     (poll_active),
                .expired (wd_expired)
            );
        end else begin : g_no_wdog
            assign wd_expired = 1'b0;
        end
    endgenerate

    dpoll_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
        .clk            (clk),
        .rst            (rst),
        .start          (start),
        .valid_addr     (valid_addr),
        .want_poll_in   (expected_data[POLL_BIT]),
        .rd_ack         (rd_ack),
        .rd_data        (rd_data),
        .verdict        (verdict),
        .wd_expired     (wd_expired),
        .rd_req         (rd_req),
        .rd_addr        (rd_addr),
        .want_poll      (want_poll),
        .poll_active    (poll_active),
        .is_idle        (is_idle),
        .done           (done),
        .pass           (pass),
        .fail           (fail),
        .data_out       (data_out),
        .data_out_valid (data_out_valid)
    );

endmodule

// File: rtl/dpoll_checker_sva.sv
module dpoll_checker_sva #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic              data_out_valid
);

    a_r1_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));

    a_r2_pass_after_read: assert property (@(posedge clk) disable iff (rst)
        pass |-> $past(rd_req && rd_ack));

    a_r5_dout_only_on_pass: assert property (@(posedge clk) disable iff (rst)
        data_out_valid |-> (done && pass));

    a_r5_pass_has_dout: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> data_out_valid);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_one_verdict: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass != fail));

    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(pass || fail));

    a_r6_done_no_req: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);

    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (!rd_req && !done && !data_out_valid));

    a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req || (done && fail)));

endmodule

bind dpoll_checker dpoll_checker_sva #(.ADDR_W(ADDR_W)) i_dpoll_sva (
    .clk            (clk),
    .rst            (rst),
    .rd_req         (rd_req),
    .rd_ack         (rd_ack),
    .rd_addr        (rd_addr),
    .done           (done),
    .pass           (pass),
    .fail           (fail),
    .data_out_valid (data_out_valid)
);

// File: tb/test_dpoll_checker.sv
module test_dpoll_checker;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int DATA_W     = 8;
    localparam int WD         = 40;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [7:0] expb;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic [7:0] b3;
        logic       ok;
        logic [3:0] nrd;
        logic [7:0] dout;
        logic       stall;
    } vec_t;

    // expected, four read bytes, pass?, reads, data_out, stall
    localparam vec_t VECS [NVEC] = '{
        '{8'h55, 8'h15, 8'h55, 8'h00, 8'h00, 1'b1, 4'd2, 8'h55, 1'b0}, // R2 first match
        '{8'h55, 8'hD5, 8'hC0, 8'h55, 8'h55, 1'b1, 4'd4, 8'h55, 1'b0}, // R3 two retries
        '{8'h55, 8'hA0, 8'h55, 8'h55, 8'h00, 1'b1, 4'd3, 8'h55, 1'b0}, // R4 recheck saves
        '{8'h55, 8'hA0, 8'hA0, 8'h00, 8'h00, 1'b0, 4'd2, 8'h00, 1'b0}, // R4 recheck fails
        '{8'hFF, 8'h00, 8'h20, 8'hFF, 8'hFF, 1'b1, 4'd4, 8'hFF, 1'b0}, // R3 R4 erase
        '{8'hFF, 8'h20, 8'h20, 8'h00, 8'h00, 1'b0, 4'd2, 8'h00, 1'b0}, // R4 erase timeout
        '{8'h80, 8'h80, 8'h81, 8'h00, 8'h00, 1'b1, 4'd2, 8'h81, 1'b0}, // R5 second byte out
        '{8'h55, 8'hD5, 8'hC0, 8'h55, 8'h55, 1'b1, 4'd4, 8'h55, 1'b1}, // R10 stalled acks
        '{8'hFF, 8'hA0, 8'hFF, 8'h00, 8'h00, 1'b1, 4'd2, 8'hFF, 1'b0}, // R5 partial byte
        '{8'hFF, 8'h20, 8'h00, 8'h00, 8'h00, 1'b0, 4'd2, 8'h00, 1'b0}  // R4 bit5 clear on recheck
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] valid_addr = '0;
    logic [DATA_W-1:0] expected_data = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              done, pass, fail, data_out_valid;
    logic [DATA_W-1:0] data_out;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [7:0]  seq [4];
    int          idx = 0;
    int          addr_err = 0;
    logic [ADDR_W-1:0] cur_addr = '0;
    bit          resp_en = 1'b0;
    bit          stall = 1'b0;
    bit          stall_ph = 1'b0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpoll_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WDOG_EN(1'b1), .WDOG_LIMIT(WD)
    ) i_dpoll_checker (
        .clk(clk), .rst(rst), .start(start), .valid_addr(valid_addr),
        .expected_data(expected_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .pass(pass),
        .fail(fail), .data_out(data_out), .data_out_valid(data_out_valid)
    );

    // Read responder: answers on the falling edge with the next scripted byte.
    always @(negedge clk) begin
        if (resp_en && rd_req && !(stall && stall_ph)) begin
            rd_ack  = 1'b1;
            rd_data = (idx < 4) ? seq[idx] : 8'h00;
            if (rd_addr !== cur_addr) addr_err++;
            idx++;
        end else begin
            rd_ack = 1'b0;
        end
        stall_ph = ~stall_ph;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [ADDR_W-1:0] a, input logic [7:0] e);
        @(negedge clk);
        valid_addr    = a;
        expected_data = e;
        start         = 1'b1;
        @(negedge clk);
        start         = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (done !== 1'b1 && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        int cyc;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: idle after reset
        chk("R8 reset rd_req", int'(rd_req), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R8 reset pass/fail", int'(pass | fail), 0);
        chk("R8 reset data_out_valid", int'(data_out_valid), 0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            seq[0] = VECS[i].b0; seq[1] = VECS[i].b1;
            seq[2] = VECS[i].b2; seq[3] = VECS[i].b3;
            idx = 0; addr_err = 0;
            stall = VECS[i].stall;
            cur_addr = ADDR_W'(18'h01000 + i * 37);
            resp_en = 1'b1;
            pulse_start(cur_addr, VECS[i].expb);
            wait_done(cyc);
            chk($sformatf("R6 vec%0d done seen", i), int'(done), 1);
            chk($sformatf("R2 R3 R4 vec%0d pass", i), int'(pass), int'(VECS[i].ok));
            chk($sformatf("R2 R3 R4 vec%0d fail", i), int'(fail), int'(!VECS[i].ok));
            chk($sformatf("R5 vec%0d data_out_valid", i), int'(data_out_valid), int'(VECS[i].ok));
            if (VECS[i].ok) chk($sformatf("R5 vec%0d data_out", i), int'(data_out), int'(VECS[i].dout));
            chk($sformatf("R10 vec%0d read count", i), idx, int'(VECS[i].nrd));
            chk($sformatf("R1 vec%0d address", i), addr_err, 0);
            @(negedge clk);
            chk($sformatf("R6 vec%0d done pulse", i), int'(done), 0);
            chk($sformatf("R6 vec%0d rd_req idle", i), int'(rd_req), 0);
        end
        stall = 1'b0;

        // R7: start while busy is ignored
        resp_en = 1'b0;
        idx = 0; addr_err = 0;
        seq[0] = 8'h15; seq[1] = 8'h55; seq[2] = 8'h00; seq[3] = 8'h00;
        cur_addr = 18'h2AAAA;
        pulse_start(18'h2AAAA, 8'h55);
        repeat (2) @(negedge clk);
        pulse_start(18'h15555, 8'hFF);
        chk("R7 R1 address kept", int'(rd_addr), int'(18'h2AAAA));
        resp_en = 1'b1;
        wait_done(cyc);
        chk("R7 pass with first expected byte", int'(pass), 1);
        chk("R7 data_out", int'(data_out), 8'h55);
        chk("R7 reads", idx, 2);
        bad = 0;
        repeat (6) begin
            @(negedge clk);
            if (rd_req || done) bad++;
        end
        chk("R7 no second operation", bad, 0);

        // R9: watchdog with no acknowledge
        resp_en = 1'b0;
        pulse_start(18'h00321, 8'h55);
        wait_done(cyc);
        chk("R9 watchdog verdict", int'(fail), 1);
        chk("R9 watchdog no pass", int'(pass), 0);
        chk("R9 watchdog latency", cyc, WD + 1);
        @(negedge clk);

        // R8: synchronous reset during an operation
        pulse_start(18'h00777, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R8 busy before reset", int'(rd_req), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 rd_req in reset", int'(rd_req), 0);
        @(negedge clk);
        rst = 1'b0;
        bad = 0;
        repeat (WD + 20) begin
            @(negedge clk);
            if (rd_req || done || pass || fail) bad++;
        end
        chk("R8 idle after reset", bad, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule